// File: doc/BRIEF.md
# SIMD shift-left-and-insert unit

This block performs a packed shift-left-and-insert on a vector of up to 128 bits. Every element of the source vector is shifted left by an immediate amount. The shifted value is then merged into the matching element of the current destination vector. The low destination bits that the shift vacates keep their old contents instead of being cleared. Bits that leave the top of an element are dropped and never reach the next element.

A single 7-bit immediate, split into a 4-bit high part and a 3-bit low part, encodes both the element size and the shift count. A width bit selects a 64-bit or a 128-bit vector. A mode flag selects between a packed vector operation and a scalar operation on one 64-bit element. Encodings that are undefined, or that belong to a different instruction class, are flagged, and in those cases the destination passes through unchanged.

Operands are captured on a valid strobe. The result appears on registered outputs one clock later. There is no back-pressure.

Top module: `sli_unit`

## Requirements
- R1: In each element, result bit b equals source bit (b - shift) when b >= shift, and equals destination bit b when b < shift.
- R2: Source bits shifted past the top of an element are discarded and do not change any bit of a neighbouring element.
- R3: In vector mode, the element size is 64, 32, 16 or 8 bits when the highest set bit of imm_hi is bit 3, 2, 1 or 0 respectively, and the shift equals the value {imm_hi, imm_lo} minus the element size (range 0 to size - 1).
- R4: In vector mode, wide = 0 gives a 64-bit operation and forces result[127:64] to zero; wide = 1 operates on all 128 bits.
- R5: In scalar mode, the operation is one 64-bit element with shift = {imm_hi, imm_lo} - 64, result[127:64] is zero, and wide is ignored.
- R6: In vector mode, imm_hi = 4'b0000 sets other_class = 1 and undef_err = 0, and result equals dst_vec unchanged.
- R7: undef_err = 1 and result = dst_vec when, in vector mode, imm_hi[3] = 1 with wide = 0, or when, in scalar mode, imm_hi[3] = 0; undef_err and other_class are never both 1.
- R8: out_valid is in_valid delayed by one clock. Results and flags update only for a cycle with in_valid = 1 and otherwise hold their values.
- R9: While rst is high and after it is released, out_valid, result, undef_err and other_class are all zero until the first valid operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this cycle are to be executed |
| src_vec | input | 128 | Vector whose elements are shifted |
| dst_vec | input | 128 | Current destination vector, source of preserved bits |
| imm_hi | input | 4 | High part of the shift immediate |
| imm_lo | input | 3 | Low part of the shift immediate |
| wide | input | 1 | 1 selects 128-bit vector, 0 selects 64-bit (vector mode) |
| scalar_mode | input | 1 | 1 selects the single 64-bit element form |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 128 | Merged vector |
| undef_err | output | 1 | Encoding was undefined |
| other_class | output | 1 | Encoding belongs to another instruction class |

## Verification
The bench builds the unit with its default parameters: a 128-bit datapath, an 8-bit minimum element and four element sizes. With this configuration, every one of the 128 immediate values can be swept under both width settings and both modes. That sweep reaches each element size at shift zero and at its maximum, as well as every undefined and foreign encoding. Directed patterns of all-ones sources over zero destinations make any carry across an element boundary visible.

// File: rtl/sli_pkg.sv
package sli_pkg;
  localparam int IMM_HI_W = 4;
  localparam int IMM_LO_W = 3;
  localparam int SIZE_W   = 2;
  localparam int SHIFT_W  = 6;

  typedef enum logic [1:0] {
    ENC_OK      = 2'd0,
    ENC_UNDEF   = 2'd1,
    ENC_FOREIGN = 2'd2
  } enc_status_e;
endpackage

// File: rtl/sli_decode.sv
module sli_decode
  import sli_pkg::*;
(
  input  logic [IMM_HI_W-1:0] imm_hi,
  input  logic [IMM_LO_W-1:0] imm_lo,
  input  logic                wide_in,
  input  logic                scalar,
  output logic [SIZE_W-1:0]   size_code,
  output logic [SHIFT_W-1:0]  shift_amt,
  output logic                wide_eff,
  output enc_status_e         status
);
  // The size comes from the highest set bit of imm_hi. Dropping that bit
  // from {imm_hi, imm_lo} is the same as subtracting the element size.
  always_comb begin
    size_code = '0;
    shift_amt = '0;
    wide_eff  = 1'b0;
    status    = ENC_OK;
    if (scalar) begin
      size_code = 2'd3;
      shift_amt = {imm_hi[2:0], imm_lo};
      if (!imm_hi[3]) status = ENC_UNDEF;
    end else begin
      wide_eff = wide_in;
      if (imm_hi[3]) begin
        size_code = 2'd3;
        shift_amt = {imm_hi[2:0], imm_lo};
        if (!wide_in) status = ENC_UNDEF;
      end else if (imm_hi[2]) begin
        size_code = 2'd2;
        shift_amt = {1'b0, imm_hi[1:0], imm_lo};
      end else if (imm_hi[1]) begin
        size_code = 2'd1;
        shift_amt = {2'b0, imm_hi[0], imm_lo};
      end else if (imm_hi[0]) begin
        size_code = 2'd0;
        shift_amt = {3'b0, imm_lo};
      end else begin
        status = ENC_FOREIGN;
      end
    end
  end
endmodule

// File: rtl/sli_elem.sv
module sli_elem #(
  parameter int EW  = 8,
  localparam int SHW = $clog2(EW)
) (
  input  logic [EW-1:0]  src,
  input  logic [EW-1:0]  dst,
  input  logic [SHW-1:0] sh,
  output logic [EW-1:0]  merged
);
  logic [EW-1:0] keep_mask;

  always_comb begin
    keep_mask = {EW{1'b1}} << sh;
    merged    = (dst & ~keep_mask) | (src << sh);
  end
endmodule

// File: rtl/sli_lanes.sv
module sli_lanes #(
  parameter int DATA_W = 128,
  parameter int EW     = 8,
  localparam int N_EL  = DATA_W / EW,
  localparam int SHW   = $clog2(EW)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [SHW-1:0]    sh,
  output logic [DATA_W-1:0] res
);
  for (genvar e = 0; e < N_EL; e++) begin : g_el
    sli_elem #(.EW(EW)) elem_i (
      .src    (src[e*EW +: EW]),
      .dst    (dst[e*EW +: EW]),
      .sh     (sh),
      .merged (res[e*EW +: EW])
    );
  end
endmodule

// File: rtl/sli_unit.sv
module sli_unit
  import sli_pkg::*;
#(
  parameter int DATA_W    = 128,
  parameter int ELEM_MIN  = 8,
  parameter int NUM_SIZES = 4,
  localparam int HALF_W   = DATA_W / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   src_vec,
  input  logic [DATA_W-1:0]   dst_vec,
  input  logic [IMM_HI_W-1:0] imm_hi,
  input  logic [IMM_LO_W-1:0] imm_lo,
  input  logic                wide,
  input  logic                scalar_mode,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic                undef_err,
  output logic                other_class
);
  logic [SIZE_W-1:0]  size_code;
  logic [SHIFT_W-1:0] shift_amt;
  logic               wide_eff;
  enc_status_e        status;

  sli_decode dec_i (
    .imm_hi    (imm_hi),
    .imm_lo    (imm_lo),
    .wide_in   (wide),
    .scalar    (scalar_mode),
    .size_code (size_code),
    .shift_amt (shift_amt),
    .wide_eff  (wide_eff),
    .status    (status)
  );

  logic [DATA_W-1:0] lane_res [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int EW_K = ELEM_MIN << k;
    localparam int SH_K = $clog2(EW_K);
    sli_lanes #(.DATA_W(DATA_W), .EW(EW_K)) lanes_i (
      .src (src_vec),
      .dst (dst_vec),
      .sh  (shift_amt[SH_K-1:0]),
      .res (lane_res[k])
    );
  end

  logic [DATA_W-1:0] sel_res;
  logic [DATA_W-1:0] next_res;

  always_comb begin
    sel_res = lane_res[size_code];
    if (!wide_eff) sel_res[DATA_W-1:HALF_W] = '0;
    next_res = (status == ENC_OK) ? sel_res : dst_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      undef_err   <= 1'b0;
      other_class <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= next_res;
        undef_err   <= (status == ENC_UNDEF);
        other_class <= (status == ENC_FOREIGN);
      end
    end
  end

  // Decoded shift stays below the decoded element size
  assert_shift_range_R3: assert property (@(posedge clk) disable iff (rst)
    (status == ENC_OK) |-> (int'(shift_amt) < (ELEM_MIN << size_code)));

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_low_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(undef_err) && $stable(other_class)));

  assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(undef_err && other_class));

  assert_err_passthru_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && status != ENC_OK) |=> (result == $past(dst_vec)));

  assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && status == ENC_OK && !wide_eff) |=> (result[DATA_W-1:HALF_W] == '0));

  assert_scalar_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar_mode) |=> (result[DATA_W-1:HALF_W] == '0 || undef_err));
endmodule

// File: tb/sli_unit_tb.sv
module sli_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] src_vec = '0;
  logic [W-1:0] dst_vec = '0;
  logic [3:0]   imm_hi = '0;
  logic [2:0]   imm_lo = '0;
  logic         wide = 1'b0;
  logic         scalar_mode = 1'b0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         undef_err;
  logic         other_class;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sli_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .src_vec(src_vec), .dst_vec(dst_vec),
    .imm_hi(imm_hi), .imm_lo(imm_lo),
    .wide(wide), .scalar_mode(scalar_mode),
    .out_valid(out_valid), .result(result),
    .undef_err(undef_err), .other_class(other_class)
  );

  // Expected value: {undef, other, result}
  function automatic logic [W+1:0] ref_model(
      input logic [W-1:0] s, input logic [W-1:0] d,
      input logic [3:0] hi, input logic [2:0] lo,
      input logic q, input logic sc);
    int ew, sh, width, pos;
    logic [W-1:0] r;
    int full;
    full = int'({hi, lo});
    if (sc) begin
      if (!hi[3]) return {1'b1, 1'b0, d};
      ew = 64; width = 64;
    end else begin
      if (hi == 4'b0000) return {1'b0, 1'b1, d};
      if (hi[3] && !q) return {1'b1, 1'b0, d};
      ew = hi[3] ? 64 : hi[2] ? 32 : hi[1] ? 16 : 8;
      width = q ? 128 : 64;
    end
    sh = full - ew;
    r = '0;
    for (int b = 0; b < width; b++) begin
      pos = b % ew;
      r[b] = (pos >= sh) ? s[b - sh] : d[b];
    end
    return {1'b0, 1'b0, r};
  endfunction

  task automatic check_op(input string tag, input logic [W-1:0] s,
      input logic [W-1:0] d, input logic [3:0] hi, input logic [2:0] lo,
      input logic q, input logic sc);
    logic [W+1:0] exp;
    exp = ref_model(s, d, hi, lo, q, sc);
    @(negedge clk);
    src_vec = s; dst_vec = d; imm_hi = hi; imm_lo = lo;
    wide = q; scalar_mode = sc; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (result !== exp[W-1:0] || undef_err !== exp[W+1] ||
        other_class !== exp[W] || out_valid !== 1'b1) begin
      failures++;
      $display("FAIL %s hi=%h lo=%h q=%b sc=%b actual res=%h u=%b o=%b v=%b expected res=%h u=%b o=%b v=1",
               tag, hi, lo, q, sc, result, undef_err, other_class, out_valid,
               exp[W-1:0], exp[W+1], exp[W]);
    end
  endtask

  function automatic logic [W-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic test_reset_R9();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || undef_err !== 1'b0 || other_class !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset actual v=%b res=%h u=%b o=%b expected all zero",
               out_valid, result, undef_err, other_class);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      failures++;
      $display("FAIL R9 after release actual v=%b res=%h expected v=0 res=0",
               out_valid, result);
    end
  endtask

  // Sweep every immediate value under both widths and both modes
  task automatic test_sweep();
    string tag;
    for (int sc = 0; sc < 2; sc++)
      for (int q = 0; q < 2; q++)
        for (int h = 0; h < 16; h++)
          for (int l = 0; l < 8; l++) begin
            if (sc == 1) tag = (h >= 8) ? "R5" : "R7";
            else if (h == 0) tag = "R6";
            else if (h >= 8 && q == 0) tag = "R7";
            else if (q == 0) tag = "R4";
            else tag = "R3";
            check_op(tag, rnd128(), rnd128(), 4'(h), 3'(l), 1'(q), 1'(sc));
          end
  endtask

  // Shift zero and maximum shift for each element size
  task automatic test_edges_R1();
    logic [3:0] hs [4] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000};
    for (int k = 0; k < 4; k++) begin
      check_op("R1", rnd128(), rnd128(), hs[k], 3'd0, 1'b1, 1'b0);
      check_op("R1", rnd128(), rnd128(), hs[k] | (hs[k] - 4'd1), 3'd7, 1'b1, 1'b0);
    end
    check_op("R5", rnd128(), rnd128(), 4'b1000, 3'd0, 1'b0, 1'b1);
    check_op("R5", rnd128(), rnd128(), 4'b1111, 3'd7, 1'b1, 1'b1);
  endtask

  // All-ones source over zero destination: no carry across elements
  task automatic test_no_cross_R2();
    for (int l = 1; l < 8; l++) begin
      check_op("R2", {W{1'b1}}, '0, 4'b0001, 3'(l), 1'b1, 1'b0);
      check_op("R2", {W{1'b1}}, '0, 4'b0011, 3'(l), 1'b1, 1'b0);
      check_op("R2", {W{1'b1}}, '0, 4'b0111, 3'(l), 1'b1, 1'b0);
    end
    check_op("R2", {W{1'b1}}, {W{1'b1}} ^ {16{8'h01}}, 4'b0001, 3'd1, 1'b1, 1'b0);
  endtask

  // Idle cycles leave outputs untouched even as inputs change
  task automatic test_hold_R8();
    logic [W-1:0] snap;
    check_op("R8", rnd128(), rnd128(), 4'b0101, 3'd3, 1'b1, 1'b0);
    snap = result;
    @(negedge clk);
    src_vec = rnd128(); dst_vec = rnd128(); imm_hi = 4'b0000; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== snap || undef_err !== 1'b0 || other_class !== 1'b0) begin
      failures++;
      $display("FAIL R8 hold actual v=%b res=%h o=%b expected v=0 res=%h o=0",
               out_valid, result, other_class, snap);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset_R9();
    test_edges_R1();
    test_no_cross_R2();
    test_hold_R8();
    test_sweep();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule